// File: doc/BRIEF.md
# Synchronized Clock Divider Bank

This block turns one fast input clock into eight divided clock outputs. Each channel has its own integer divider, enable bit and 4-bit start-delay code. An active-low sync input stops every channel and then restarts all of them from a common phase. As a result, outputs whose ratios are integer multiples of each other stay edge-aligned. The divider and delay values are captured only when a channel restarts, so software can stage new settings and apply all of them together with one sync event.

A channel drives its output only when three enables are high: its own enable bit, a global enable register bit and a global-enable pin. A lock-detect signal from a PLL can drive that pin, so the whole bank goes quiet while the loop is unlocked. The analog fine delay is modelled as a whole-cycle shift: the code sets how many input-clock cycles a channel's first rising edge lags the common restart edge. Configuration arrives on plain register ports.

Top module: `clk_out_bank`

## Requirements
- R1: While `rst_ni` is low, every output is low. With `sync_ni` high, the first restart happens on the sixth rising edge after reset is released. On that edge, channels with delay code 0 go high.
- R2: A sync low counts only if `sync_ni` is sampled low on two consecutive rising edges. A low seen on one edge only has no effect on any output.
- R3: When a sync low is accepted on edge L (the second low sample), every output is low from edge L+4 on. Outputs stay low while the low level is held.
- R4: When `sync_ni` is sampled high on two consecutive edges, with the second at edge H, all channels restart from a common phase on edge H+4. Every channel with delay code 0 rises on that edge.
- R5: With divide field N in the range 1..255, a running channel is high for N input cycles and then low for N input cycles. This gives a period of 2N and a 50% duty cycle.
- R6: With divide field N = 0, a running channel passes the input clock through: high while `clk_i` is high and low while it is low.
- R7: A channel with delay code D (0..15) stays low after the restart edge and rises first on restart edge + D.
- R8: Changes to a channel's divide field or delay code have no effect on its output until the next restart. The values present on the restart edge are the ones that are used.
- R9: A channel whose `ch_en_i` bit is low drives its output low. Its divider keeps counting, so re-enabling it resumes at the common phase.
- R10: When `goe_i` or `glob_en_i` is low, every output is low at once. The dividers keep their phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast input clock; all logic runs on its rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sync_ni | input | 1 | Active-low sync; holds outputs low, then restarts them in phase |
| goe_i | input | 1 | Global-enable pin, active high (for example driven by lock detect) |
| glob_en_i | input | 1 | Global enable register bit |
| ch_en_i | input | 8 | Per-channel enable bits |
| div_n_i | input | 64 | Per-channel divide field N, 8 bits each, channel k at bits 8k+7:8k; divide = 2N, 0 = bypass |
| dly_i | input | 32 | Per-channel delay code, 4 bits each, channel k at bits 4k+3:4k |
| clk_o | output | 8 | Gated channel clock outputs |

## Verification
Four properties are checked on every cycle:
- the sync filter only enters the held state after two consecutive low samples;
- every channel's internal output state is low five edges after a two-sample low;
- no output is ever high while the global pin or the global bit is low;
- no output is ever high while its own enable is low.

The following can only be shown by the bench scenarios, which compare every cycle against a cycle-level reference model:
- the common restart edge after release;
- the per-channel first-edge delay;
- the 2N period and bypass passthrough;
- the rejection of one-cycle sync glitches;
- the deferral of configuration changes to the next restart.

// File: rtl/clk_bank_pkg.sv
package clk_bank_pkg;
  localparam int unsigned NUM_CH_DEF   = 8;
  localparam int unsigned DIV_W_DEF    = 8;
  localparam int unsigned DLY_W_DEF    = 4;
  localparam int unsigned SYNC_LAT_DEF = 4;

  typedef enum logic [1:0] {
    CH_IDLE = 2'd0,
    CH_WAIT = 2'd1,
    CH_RUN  = 2'd2
  } ch_state_e;
endpackage

// File: rtl/sync_ctrl.sv
module sync_ctrl #(
  parameter int unsigned SYNC_LAT = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sync_ni,
  output logic hold_o,
  output logic start_o
);
  logic                smp_q;
  logic                filt_q;
  logic [SYNC_LAT-1:0] lat_q;

  // filt_q: 1 = held; changes only after two equal consecutive samples
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      smp_q  <= 1'b0;
      filt_q <= 1'b1;
    end else begin
      smp_q <= sync_ni;
      if (!smp_q && !sync_ni)     filt_q <= 1'b1;
      else if (smp_q && sync_ni)  filt_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lat_q <= '1;
    else         lat_q <= {lat_q[SYNC_LAT-2:0], filt_q};
  end

  // tap SYNC_LAT-2 feeds registers that update on the SYNC_LAT-th edge
  assign hold_o  = lat_q[SYNC_LAT-2];
  assign start_o = ~lat_q[SYNC_LAT-2] & lat_q[SYNC_LAT-1];
endmodule

// File: rtl/div_chan.sv
module div_chan
  import clk_bank_pkg::*;
#(
  parameter int unsigned DIV_W = 8,
  parameter int unsigned DLY_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hold_i,
  input  logic             start_i,
  input  logic [DIV_W-1:0] div_n_i,
  input  logic [DLY_W-1:0] dly_i,
  output logic             gate_o,
  output logic             bypass_o
);
  ch_state_e        st_q;
  logic [DIV_W-1:0] n_q;
  logic [DIV_W-1:0] cnt_q;
  logic [DLY_W-1:0] wait_q;
  logic             gate_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= CH_IDLE;
      n_q    <= '0;
      cnt_q  <= '0;
      wait_q <= '0;
      gate_q <= 1'b0;
    end else if (hold_i) begin
      st_q   <= CH_IDLE;
      cnt_q  <= '0;
      wait_q <= '0;
      gate_q <= 1'b0;
    end else if (start_i) begin
      // settings captured only here
      n_q   <= div_n_i;
      cnt_q <= '0;
      if (dly_i == '0) begin
        st_q   <= CH_RUN;
        gate_q <= 1'b1;
      end else begin
        st_q   <= CH_WAIT;
        wait_q <= dly_i;
        gate_q <= 1'b0;
      end
    end else begin
      case (st_q)
        CH_WAIT: begin
          wait_q <= wait_q - 1'b1;
          if (wait_q == DLY_W'(1)) begin
            st_q   <= CH_RUN;
            gate_q <= 1'b1;
            cnt_q  <= '0;
          end
        end
        CH_RUN: begin
          if (n_q != '0) begin
            if (cnt_q == n_q - 1'b1) begin
              gate_q <= ~gate_q;
              cnt_q  <= '0;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign gate_o   = gate_q;
  assign bypass_o = (n_q == '0);
endmodule

// File: rtl/out_gate.sv
module out_gate (
  input  logic clk_i,
  input  logic en_i,
  input  logic gate_i,
  input  logic bypass_i,
  output logic clk_o
);
  // bypass passes the input clock, else the divided level
  assign clk_o = en_i & gate_i & (~bypass_i | clk_i);
endmodule

// File: rtl/clk_out_bank.sv
module clk_out_bank
  import clk_bank_pkg::*;
#(
  parameter int unsigned NUM_CH   = NUM_CH_DEF,
  parameter int unsigned DIV_W    = DIV_W_DEF,
  parameter int unsigned DLY_W    = DLY_W_DEF,
  parameter int unsigned SYNC_LAT = SYNC_LAT_DEF
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    sync_ni,
  input  logic                    goe_i,
  input  logic                    glob_en_i,
  input  logic [NUM_CH-1:0]       ch_en_i,
  input  logic [NUM_CH*DIV_W-1:0] div_n_i,
  input  logic [NUM_CH*DLY_W-1:0] dly_i,
  output logic [NUM_CH-1:0]       clk_o
);
  logic              hold_w;
  logic              start_w;
  logic              en_all_w;
  logic [NUM_CH-1:0] gate_w;
  logic [NUM_CH-1:0] byp_w;

  assign en_all_w = goe_i & glob_en_i;

  sync_ctrl #(.SYNC_LAT(SYNC_LAT)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sync_ni (sync_ni),
    .hold_o  (hold_w),
    .start_o (start_w)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    div_chan #(.DIV_W(DIV_W), .DLY_W(DLY_W)) u_div (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .hold_i   (hold_w),
      .start_i  (start_w),
      .div_n_i  (div_n_i[g*DIV_W +: DIV_W]),
      .dly_i    (dly_i[g*DLY_W +: DLY_W]),
      .gate_o   (gate_w[g]),
      .bypass_o (byp_w[g])
    );

    out_gate u_gate (
      .clk_i    (clk_i),
      .en_i     (en_all_w & ch_en_i[g]),
      .gate_i   (gate_w[g]),
      .bypass_i (byp_w[g]),
      .clk_o    (clk_o[g])
    );
  end
endmodule

// File: rtl/clk_bank_chk.sv
module clk_bank_chk #(
  parameter int unsigned NUM_CH = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sync_ni,
  input logic              goe_i,
  input logic              glob_en_i,
  input logic [NUM_CH-1:0] ch_en_i,
  input logic [NUM_CH-1:0] clk_o,
  input logic              filt_i,
  input logic [NUM_CH-1:0] gate_i
);
  logic [3:0] age_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             age_q <= '0;
    else if (age_q != 4'hf)  age_q <= age_q + 1'b1;
  end

  // R2
  sync_filt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q >= 4'd3 && $rose(filt_i)) |-> (!$past(sync_ni) && !$past(sync_ni, 2)));

  // R3
  hold_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q >= 4'd7 && !$past(sync_ni, 5) && !$past(sync_ni, 6)) |-> (gate_i == '0));

  // R10
  glob_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(goe_i && glob_en_i) |-> (clk_o == '0));

  // R9
  ch_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((clk_o & ~ch_en_i) == '0));
endmodule

bind clk_out_bank clk_bank_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .sync_ni   (sync_ni),
  .goe_i     (goe_i),
  .glob_en_i (glob_en_i),
  .ch_en_i   (ch_en_i),
  .clk_o     (clk_o),
  .filt_i    (u_sync.filt_q),
  .gate_i    (gate_w)
);

// File: tb/sim_clk_out_bank.sv
module sim_clk_out_bank;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int NC = 8;
  localparam int DW = 8;
  localparam int LW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sync_n = 1'b1;
  logic          goe = 1'b1;
  logic          gen = 1'b1;
  logic [NC-1:0] ch_en = '1;
  logic [NC*DW-1:0] div_n = '0;
  logic [NC*LW-1:0] dly = '0;
  wire  [NC-1:0] clk_out;

  int    checks = 0;
  int    errors = 0;
  string cur_req = "R1";

  always #2.5 clk = ~clk;

  clk_out_bank u0 (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .sync_ni   (sync_n),
    .goe_i     (goe),
    .glob_en_i (gen),
    .ch_en_i   (ch_en),
    .div_n_i   (div_n),
    .dly_i     (dly),
    .clk_o     (clk_out)
  );

  // reference model state
  int   cyc;
  logic m_prev, m_filt, m_hold_prev, m_started;
  logic m_fh [5];
  int   m_st;
  int   m_n [NC];
  int   m_d [NC];

  function automatic logic exp_gate(int ch);
    int rel;
    if (!m_started) return 1'b0;
    rel = cyc - m_st;
    if (rel < m_d[ch]) return 1'b0;
    if (m_n[ch] == 0) return 1'b1;
    return (((rel - m_d[ch]) / m_n[ch]) % 2) == 0;
  endfunction

  task automatic chk(bit ok, string req, logic [NC-1:0] act, logic [NC-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%b exp=%b t=%0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison, sampled 1 ns after the rising edge (clk high)
  always @(posedge clk) begin
    #1;
    if (!rst_n) begin
      cyc = 0; m_prev = 1'b0; m_filt = 1'b1; m_hold_prev = 1'b1; m_started = 1'b0;
      for (int k = 0; k < 5; k++) m_fh[k] = 1'b1;
      chk(clk_out == '0, "R1", clk_out, '0);
    end else begin
      logic hold_now;
      logic [NC-1:0] ev;
      cyc++;
      if (!m_prev && !sync_n) m_filt = 1'b1;
      else if (m_prev && sync_n) m_filt = 1'b0;
      m_prev = sync_n;
      for (int k = 4; k > 0; k--) m_fh[k] = m_fh[k-1];
      m_fh[0] = m_filt;
      hold_now = m_fh[4];
      if (hold_now) m_started = 1'b0;
      else if (m_hold_prev) begin
        m_started = 1'b1;
        m_st = cyc;
        for (int c = 0; c < NC; c++) begin
          m_n[c] = int'(div_n[c*DW +: DW]);
          m_d[c] = int'(dly[c*LW +: LW]);
        end
      end
      m_hold_prev = hold_now;
      for (int c = 0; c < NC; c++) ev[c] = goe & gen & ch_en[c] & exp_gate(c);
      chk(clk_out == ev, cur_req, clk_out, ev);
    end
  end

  task automatic set_cfg(int ch, int n, int d);
    div_n[ch*DW +: DW] = DW'(n);
    dly[ch*LW +: LW]   = LW'(d);
  endtask

  task automatic run(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sync_pulse(int len);
    @(negedge clk) sync_n = 1'b0;
    run(len);
    sync_n = 1'b1;
  endtask

  initial begin
    #900000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_c10c));
    set_cfg(0, 1, 0);   set_cfg(1, 2, 0);   set_cfg(2, 3, 2);  set_cfg(3, 0, 0);
    set_cfg(4, 5, 15);  set_cfg(5, 255, 1); set_cfg(6, 4, 3);  set_cfg(7, 7, 0);
    #12;
    chk(clk_out == '0, "R1", clk_out, '0);
    @(negedge clk) rst_n = 1'b1;
    // R1: first restart on the sixth edge after release
    repeat (5) @(posedge clk);
    #1.5 chk(clk_out == '0, "R1", clk_out, '0);
    @(posedge clk);
    #1.5 chk(clk_out == 8'b1000_1011, "R1", clk_out, 8'b1000_1011);

    cur_req = "R5";
    run(60);

    // R6: bypass channel follows clk_i
    cur_req = "R6";
    @(negedge clk); #1 chk(clk_out[3] == 1'b0, "R6", clk_out, '0);
    @(posedge clk); #1.5 chk(clk_out[3] == 1'b1, "R6", clk_out, 8'h08);

    // R2: one-sample glitch ignored
    cur_req = "R2";
    sync_pulse(1);
    run(30);

    // R3 hold, then R8 staged change, then R4/R7 release
    cur_req = "R3";
    sync_pulse(10);
    #1 chk(clk_out == '0, "R3", clk_out, '0);
    cur_req = "R4";
    run(20);
    cur_req = "R8";
    set_cfg(1, 6, 4);
    set_cfg(0, 2, 1);
    run(40);
    cur_req = "R7";
    sync_pulse(3);
    run(80);

    // R9: per-channel enables toggled
    cur_req = "R9";
    for (int i = 0; i < 40; i++) begin
      @(negedge clk) ch_en = NC'($urandom);
    end
    ch_en = '1;
    run(10);

    // R10: global pin and bit
    cur_req = "R10";
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      goe = ($urandom_range(0, 3) != 0);
      gen = ($urandom_range(0, 3) != 0);
    end
    goe = 1'b1; gen = 1'b1;
    run(10);

    // random configurations and sync lengths
    cur_req = "R5";
    for (int it = 0; it < 40; it++) begin
      @(negedge clk);
      for (int c = 0; c < NC; c++)
        set_cfg(c, ($urandom_range(0, 9) == 0) ? 255 : int'($urandom_range(0, 40)),
                int'($urandom_range(0, 15)));
      sync_pulse(int'($urandom_range(1, 7)));
      for (int j = 0; j < 8; j++) begin
        @(negedge clk);
        ch_en = NC'($urandom) | NC'($urandom);
      end
      run(int'($urandom_range(20, 300)));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule